// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the clocked read front end of a NOR-style memory. A host presents a word address together with an address-valid strobe. Once the configuration register selects synchronous operation, the sequencer counts a programmable number of clocks and then delivers one 16-bit word per data slot from a behavioural array model, or from a non-array source such as a status or identifier word. Bursts are 4, 8 or 16 words long, or continuous. Fixed bursts either wrap inside their aligned group or step linearly.

A WAIT output tells the host when the data bus carries nothing useful. The configuration register sets its active level. It can also move WAIT one clock ahead of the invalid slot it announces. A continuous burst that steps into a new array row stalls once for one clock less than the first-access latency, and WAIT marks that stall. WAIT is qualified by a drive-enable output that follows chip enable and output enable.

Top module: `burst_read_seq`

## Requirements
- R1: After reset the configuration register holds 0x0400, which selects asynchronous mode and an active-high WAIT. dataValid is low and waitOe is low while chipEn is low.
- R2: While configuration bit 15 is 0 (asynchronous mode), addrValid is ignored and dataValid stays low.
- R3: With bit 15 at 1, the first word is valid exactly L clocks after the edge that samples addrValid with chipEn high. L is taken from bits 14:11. Codes 0 and 1 act as 2.
- R4: Bits 2:0 select the burst length: 001 gives 4 words, 010 gives 8, 011 gives 16, and every other code gives a continuous burst. A fixed burst delivers exactly that many words and then drops dataValid.
- R5: If bit 3 is 1, a fixed burst wraps its address inside the group of burst-length words aligned on that length. If bit 3 is 0 it increments linearly. A continuous burst is always linear.
- R6: An array read at word address a returns a XOR 0xA53C.
- R7: A continuous array burst whose next address is a multiple of the row size (16 words) inserts L-1 clocks without valid data, the first time only. Later crossings, and crossings inside fixed bursts, insert no gap.
- R8: When spaceSel is high at the start strobe, every word of the burst equals statusWord.
- R9: With bit 9 at 1, each word stays on dataOut with dataValid high for two clocks.
- R10: Bit 10 sets the WAIT level. When it is 1, WAIT is asserted as 1. When it is 0, WAIT is asserted as 0. The deasserted level is the opposite.
- R11: With bit 8 at 0, WAIT is asserted in every clock of an active burst that has no valid data. With bit 8 at 1, WAIT is asserted one clock ahead of each such invalid clock instead.
- R12: waitOe is high exactly when chipEn and outEn are both high.
- R13: chipEn low at an edge ends any burst, so dataValid is low after that edge. A new start strobe restarts the burst even on the last word of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Load the read configuration register |
| cfgWrData | input | 16 | New configuration value |
| chipEn | input | 1 | Chip enable, active high |
| outEn | input | 1 | Output enable, active high |
| addrValid | input | 1 | Start strobe; latches addrIn and spaceSel |
| addrIn | input | AW | Start word address |
| spaceSel | input | 1 | 1 selects the non-array word source |
| statusWord | input | DW | Non-array word (status or identifier) |
| dataOut | output | DW | Burst data |
| dataValid | output | 1 | dataOut carries a burst word |
| waitOut | output | 1 | WAIT level |
| waitOe | output | 1 | WAIT drive enable for the pad |

## Verification
Two pairs of events can land in the same clock, and the bench provokes both. First, a new start strobe is driven in the clock that shows the last word of a fixed burst. Every word of the old burst must still be observed, and the new latency must count from that edge. Second, a continuous burst steps into a new row while WAIT marks the resulting stall. Every delivered word and its cycle number are compared against a queue built from the requirements, and WAIT is sampled during the stall and just after it.

// File: rtl/burst_rd_pkg.sv
package burst_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LAT,
    ST_XFER,
    ST_STALL
  } seqState_t;

  // Read configuration register layout (bit 15 down to bit 0)
  typedef struct packed {
    logic       syncMode;   // 15
    logic [3:0] latCode;    // 14:11
    logic       waitPol;    // 10
    logic       holdTwo;    // 9
    logic       waitEarly;  // 8
    logic [3:0] spare;      // 7:4
    logic       wrapEn;     // 3
    logic [2:0] lenCode;    // 2:0
  } rdCfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch start address and space select
    logic loadCur;   // output word at current address
    logic step;      // advance current address
    logic loadNext;  // output word at next address
  } dpStrobe_t;

  localparam logic [15:0] CFG_RESET = 16'h0400;
  localparam int          LAT_W     = 4;
  localparam int          MIN_LAT   = 2;

endpackage

// File: rtl/burst_array_model.sv
module burst_array_model #(
  parameter int          AW   = 16,
  parameter int          DW   = 16,
  parameter logic [DW-1:0] SEED = 'hA53C
) (
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdWord
);

  logic [DW-1:0] addrFit;

  generate
    if (AW >= DW) begin : g_trunc
      assign addrFit = rdAddr[DW-1:0];
    end else begin : g_ext
      assign addrFit = {{(DW-AW){1'b0}}, rdAddr};
    end
  endgenerate

  assign rdWord = addrFit ^ SEED;

endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_rd_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgWrEn,
  input  logic [15:0] cfgWrData,
  input  logic      chipEn,
  input  logic      addrValid,
  input  logic      rowCross,
  input  logic      nonArr,
  output rdCfg_t    cfgQ,
  output dpStrobe_t strobe,
  output logic      dataValid,
  output logic      waitAct
);

  seqState_t        st, stD;
  logic [LAT_W-1:0] cnt, cntD;
  logic [LAT_W-1:0] effLat;
  logic [CNT_W-1:0] wordsLeft, wordsD, burstLen;
  logic             holdQ, holdD, holdLast;
  logic             crossed, crossedD;
  logic             contQ, contD, isCont;
  logic             validQ, validD;
  logic             startReq;

  // configuration register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= rdCfg_t'(CFG_RESET);
    else if (cfgWrEn) cfgQ <= rdCfg_t'(cfgWrData);
  end

  always_comb begin
    effLat = (cfgQ.latCode < LAT_W'(MIN_LAT)) ? LAT_W'(MIN_LAT) : cfgQ.latCode;
    case (cfgQ.lenCode)
      3'd1:    burstLen = CNT_W'(4);
      3'd2:    burstLen = CNT_W'(8);
      3'd3:    burstLen = CNT_W'(16);
      default: burstLen = '0;
    endcase
    isCont   = (burstLen == '0);
    holdLast = cfgQ.holdTwo ? holdQ : 1'b1;
    startReq = addrValid && chipEn && cfgQ.syncMode;
  end

  always_comb begin
    stD      = st;
    cntD     = cnt;
    wordsD   = wordsLeft;
    holdD    = holdQ;
    crossedD = crossed;
    contD    = contQ;
    validD   = validQ;
    strobe   = '0;
    if (!chipEn) begin
      stD    = ST_IDLE;
      validD = 1'b0;
    end else if (startReq) begin
      strobe.capture = 1'b1;
      stD      = ST_LAT;
      cntD     = effLat;
      validD   = 1'b0;
      holdD    = 1'b0;
      wordsD   = burstLen;
      crossedD = 1'b0;
      contD    = isCont;
    end else begin
      case (st)
        ST_LAT, ST_STALL: begin
          if (cnt == LAT_W'(1)) begin
            strobe.loadCur = 1'b1;
            validD = 1'b1;
            holdD  = 1'b0;
            stD    = ST_XFER;
          end else begin
            cntD = cnt - LAT_W'(1);
          end
        end
        ST_XFER: begin
          if (holdLast) begin
            if (!contQ && wordsLeft == CNT_W'(1)) begin
              stD    = ST_IDLE;
              validD = 1'b0;
            end else begin
              if (!contQ) wordsD = wordsLeft - CNT_W'(1);
              strobe.step = 1'b1;
              holdD = 1'b0;
              if (contQ && rowCross && !nonArr && !crossed) begin
                stD      = ST_STALL;
                cntD     = effLat - LAT_W'(1);
                validD   = 1'b0;
                crossedD = 1'b1;
              end else begin
                strobe.loadNext = 1'b1;
              end
            end
          end else begin
            holdD = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      wordsLeft <= '0;
      holdQ     <= 1'b0;
      crossed   <= 1'b0;
      contQ     <= 1'b0;
      validQ    <= 1'b0;
    end else begin
      st        <= stD;
      cnt       <= cntD;
      wordsLeft <= wordsD;
      holdQ     <= holdD;
      crossed   <= crossedD;
      contQ     <= contD;
      validQ    <= validD;
    end
  end

  assign dataValid = validQ;

  // logical WAIT: either the present slot is empty, or (early mode) the next one
  always_comb begin
    if (st == ST_IDLE) waitAct = 1'b0;
    else if (cfgQ.waitEarly) waitAct = !validD && (stD != ST_IDLE);
    else waitAct = !validQ;
  end

endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_rd_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int ROW_WORDS = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  rdCfg_t        cfgQ,
  input  logic [AW-1:0] addrIn,
  input  logic          spaceSel,
  input  logic [DW-1:0] statusWord,
  input  logic [DW-1:0] arrWord,
  output logic [AW-1:0] arrAddr,
  output logic [DW-1:0] dataOut,
  output logic          rowCross,
  output logic          nonArrQ
);

  localparam int ROW_W = (ROW_WORDS > 1) ? $clog2(ROW_WORDS) : 1;

  logic [AW-1:0] curAddr, nextAddr, grpMask, incAddr;
  logic [DW-1:0] dataQ;
  logic          wrapOn;

  always_comb begin
    case (cfgQ.lenCode)
      3'd1:    grpMask = AW'(3);
      3'd2:    grpMask = AW'(7);
      3'd3:    grpMask = AW'(15);
      default: grpMask = '0;
    endcase
    wrapOn   = cfgQ.wrapEn && (grpMask != '0);
    incAddr  = curAddr + AW'(1);
    nextAddr = wrapOn ? ((curAddr & ~grpMask) | (incAddr & grpMask)) : incAddr;
    rowCross = (nextAddr[ROW_W-1:0] == '0);
    arrAddr  = strobe.loadNext ? nextAddr : curAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      nonArrQ <= 1'b0;
      dataQ   <= '0;
    end else begin
      if (strobe.capture) begin
        curAddr <= addrIn;
        nonArrQ <= spaceSel;
      end else if (strobe.step) begin
        curAddr <= nextAddr;
      end
      if (strobe.loadCur || strobe.loadNext)
        dataQ <= nonArrQ ? statusWord : arrWord;
    end
  end

  assign dataOut = dataQ;

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import burst_rd_pkg::*;
#(
  parameter int            AW         = 16,
  parameter int            DW         = 16,
  parameter int            ROW_WORDS  = 16,
  parameter logic [DW-1:0] ARRAY_SEED = 'hA53C
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWrEn,
  input  logic [15:0]   cfgWrData,
  input  logic          chipEn,
  input  logic          outEn,
  input  logic          addrValid,
  input  logic [AW-1:0] addrIn,
  input  logic          spaceSel,
  input  logic [DW-1:0] statusWord,
  output logic [DW-1:0] dataOut,
  output logic          dataValid,
  output logic          waitOut,
  output logic          waitOe
);

  rdCfg_t        cfgQ;
  dpStrobe_t     strobe;
  logic          rowCross, nonArrQ, waitAct;
  logic [AW-1:0] arrAddr;
  logic [DW-1:0] arrWord;

  burst_seq_ctrl #(.CNT_W(5)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .chipEn(chipEn), .addrValid(addrValid), .rowCross(rowCross),
    .nonArr(nonArrQ), .cfgQ(cfgQ), .strobe(strobe),
    .dataValid(dataValid), .waitAct(waitAct)
  );

  burst_seq_dp #(.AW(AW), .DW(DW), .ROW_WORDS(ROW_WORDS)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgQ(cfgQ),
    .addrIn(addrIn), .spaceSel(spaceSel), .statusWord(statusWord),
    .arrWord(arrWord), .arrAddr(arrAddr), .dataOut(dataOut),
    .rowCross(rowCross), .nonArrQ(nonArrQ)
  );

  burst_array_model #(.AW(AW), .DW(DW), .SEED(ARRAY_SEED)) array_i (
    .rdAddr(arrAddr), .rdWord(arrWord)
  );

  assign waitOe  = chipEn && outEn;
  assign waitOut = waitOe && (cfgQ.waitPol ? waitAct : !waitAct);

endmodule

// File: rtl/burst_read_seq_chk.sv
module burst_read_seq_chk
  import burst_rd_pkg::*;
#(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          chipEn,
  input logic          addrValid,
  input logic          dataValid,
  input logic [DW-1:0] dataOut,
  input logic          waitOut,
  input logic          waitOe,
  input rdCfg_t        cfgQ
);

  // R13
  ce_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chipEn |=> !dataValid);

  // R3
  start_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && chipEn && cfgQ.syncMode) |=> !dataValid);

  // R11
  wait_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (waitOe && dataValid && !cfgQ.waitEarly) |-> (waitOut != cfgQ.waitPol));

  // R9
  hold_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ.holdTwo && $rose(dataValid) && chipEn && !addrValid)
      |=> (dataValid && $stable(dataOut)));

endmodule

bind burst_read_seq burst_read_seq_chk #(.DW(DW)) chk_i (
  .clk(clk), .rstN(rstN), .chipEn(chipEn), .addrValid(addrValid),
  .dataValid(dataValid), .dataOut(dataOut), .waitOut(waitOut),
  .waitOe(waitOe), .cfgQ(cfgQ)
);

// File: tb/burst_read_seq_tb_top.sv
module burst_read_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [15:0] cfgWrData = '0;
  logic        chipEn = 1'b0;
  logic        outEn = 1'b0;
  logic        addrValid = 1'b0;
  logic [15:0] addrIn = '0;
  logic        spaceSel = 1'b0;
  logic [15:0] statusWord = '0;
  logic [15:0] dataOut;
  logic        dataValid, waitOut, waitOe;

  int edgeCnt = 0;
  int checkCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [15:0] data;
    int          cyc;
    string       req;
  } expItem_t;
  expItem_t expQ[$];

  burst_read_seq dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .chipEn(chipEn), .outEn(outEn), .addrValid(addrValid), .addrIn(addrIn),
    .spaceSel(spaceSel), .statusWord(statusWord), .dataOut(dataOut),
    .dataValid(dataValid), .waitOut(waitOut), .waitOe(waitOe)
  );

  always #2 clk = ~clk;
  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishUp();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  endtask

  // monitor: pops expected words as the design delivers them
  always @(negedge clk) begin
    if (rstN) begin
      while (expQ.size() > 0 && expQ[0].cyc < edgeCnt) begin
        check(1'b0, expQ[0].req, "missed word at cycle", edgeCnt, expQ[0].cyc);
        void'(expQ.pop_front());
      end
      if (dataValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R4", "unexpected valid word", int'(dataOut), 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(it.cyc == edgeCnt, it.req, "word cycle", edgeCnt, it.cyc);
          check(it.data == dataOut, it.req, "word data", int'(dataOut), int'(it.data));
        end
      end
    end
  end

  function automatic logic [15:0] mkCfg(bit sync, int lat, bit pol, bit hold,
                                        bit early, bit wrap, int len);
    return {sync, 4'(lat), pol, hold, early, 4'b0000, wrap, 3'(len)};
  endfunction

  task automatic writeCfg(input logic [15:0] v);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // expected word stream from the requirements (R4..R9)
  task automatic pushBurst(input int addr, input int nWords, input int grp,
                           input int lat, input int hold, input bit cont,
                           input bit nonArr, input logic [15:0] status,
                           input int cap, input string req, output int lastCyc);
    int cyc = cap + lat;
    int a = addr;
    bit crossed = 1'b0;
    lastCyc = cyc;
    for (int i = 0; i < nWords; i++) begin
      int nxt;
      for (int h = 0; h < hold; h++) begin
        expItem_t it;
        it.data = nonArr ? status : (16'(a) ^ 16'hA53C);
        it.cyc = cyc;
        it.req = req;
        expQ.push_back(it);
        lastCyc = cyc;
        cyc++;
      end
      if (grp != 0) nxt = (a & ~(grp - 1)) | ((a + 1) & (grp - 1));
      else nxt = (a + 1) & 16'hFFFF;
      if (cont && !nonArr && !crossed && (nxt % 16) == 0) begin
        cyc += lat - 1;
        crossed = 1'b1;
      end
      a = nxt;
    end
  endtask

  // called at a negedge; the strobe is sampled at the next edge
  task automatic runBurst(input int addr, input bit space, input logic [15:0] status,
                          input int nWords, input int grp, input int lat, input int hold,
                          input bit cont, input string req, output int cap, output int lastCyc);
    addrIn = 16'(addr);
    spaceSel = space;
    statusWord = status;
    addrValid = 1'b1;
    cap = edgeCnt + 1;
    pushBurst(addr, nWords, grp, lat, hold, cont, space, status, cap, req, lastCyc);
    @(negedge clk);
    addrValid = 1'b0;
  endtask

  task automatic waitUntil(input int cyc);
    while (edgeCnt < cyc) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R4", "watchdog expired", edgeCnt, 0);
    finishUp();
  end

  initial begin
    int cap, lastCyc, cap2, lastCyc2, cnt;

    // reset state (R1, R12)
    repeat (3) @(negedge clk);
    check(dataValid == 1'b0, "R1", "dataValid in reset", int'(dataValid), 0);
    check(waitOe == 1'b0, "R1", "waitOe with chipEn low", int'(waitOe), 0);
    rstN = 1'b1;
    @(negedge clk);
    chipEn = 1'b1;
    outEn = 1'b1;
    #1;
    check(waitOe == 1'b1, "R12", "waitOe with both enables", int'(waitOe), 1);
    check(waitOut == 1'b0, "R10", "idle WAIT active-high default", int'(waitOut), 0);

    // R2: asynchronous mode ignores the strobe
    @(negedge clk);
    addrIn = 16'h0010;
    addrValid = 1'b1;
    @(negedge clk);
    addrValid = 1'b0;
    cnt = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (dataValid) cnt++;
    end
    check(cnt == 0, "R2", "valid words in async mode", cnt, 0);

    // R3 R4 R5 R6 R11: 4-word wrap, latency 4, WAIT with the data slot
    writeCfg(mkCfg(1, 4, 1, 0, 0, 1, 1));
    runBurst(16'h42, 0, 16'h0, 4, 4, 4, 1, 0, "R5", cap, lastCyc);
    for (int k = 0; k < 9; k++) begin
      bit expW;
      #1;
      expW = (edgeCnt < cap + 4);
      check(waitOut == expW, "R11", "WAIT level, normal timing", int'(waitOut), int'(expW));
      @(negedge clk);
    end
    waitUntil(lastCyc + 2);

    // R10 R11 R7: active-low early WAIT, 8-word linear crossing a row, no gap
    writeCfg(mkCfg(1, 4, 0, 0, 1, 0, 2));
    #1;
    check(waitOut == 1'b1, "R10", "idle WAIT active-low", int'(waitOut), 1);
    @(negedge clk);
    runBurst(16'h1D, 0, 16'h0, 8, 0, 4, 1, 0, "R7", cap, lastCyc);
    for (int k = 0; k < 13; k++) begin
      bit expW;
      #1;
      expW = (edgeCnt < cap + 3) ? 1'b0 : 1'b1;
      check(waitOut == expW, "R11", "WAIT level, early timing", int'(waitOut), int'(expW));
      @(negedge clk);
    end
    waitUntil(lastCyc + 2);

    // R3: reserved latency code behaves as 2; 16-word wrap (R5)
    writeCfg(mkCfg(1, 1, 1, 0, 0, 1, 3));
    @(negedge clk);
    runBurst(16'h23, 0, 16'h0, 16, 16, 2, 1, 0, "R3", cap, lastCyc);
    waitUntil(lastCyc + 2);

    // R9: two-clock data hold
    writeCfg(mkCfg(1, 3, 1, 1, 0, 1, 1));
    @(negedge clk);
    runBurst(16'h05, 0, 16'h0, 4, 4, 3, 2, 0, "R9", cap, lastCyc);
    waitUntil(lastCyc + 2);

    // R8: non-array space repeats one word
    writeCfg(mkCfg(1, 5, 1, 0, 0, 0, 2));
    @(negedge clk);
    runBurst(16'h40, 1, 16'hBEEF, 8, 0, 5, 1, 0, "R8", cap, lastCyc);
    waitUntil(lastCyc + 2);

    // R7 R13: continuous burst, one stall at first row crossing, ended by chipEn
    writeCfg(mkCfg(1, 3, 0, 0, 0, 1, 7));
    @(negedge clk);
    runBurst(16'h0E, 0, 16'h0, 22, 0, 3, 1, 1, "R7", cap, lastCyc);
    while (edgeCnt < lastCyc) begin
      #1;
      if (edgeCnt == cap + 5)
        check(waitOut == 1'b0, "R11", "WAIT asserted in row stall", int'(waitOut), 0);
      if (edgeCnt == cap + 7)
        check(waitOut == 1'b1, "R11", "WAIT released after stall", int'(waitOut), 1);
      @(negedge clk);
    end
    chipEn = 1'b0;
    #1;
    check(waitOe == 1'b0, "R12", "waitOe with chipEn low", int'(waitOe), 0);
    cnt = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (dataValid) cnt++;
    end
    check(cnt == 0, "R13", "words after chipEn low", cnt, 0);
    chipEn = 1'b1;

    // R13: restart strobe in the clock of the last word
    writeCfg(mkCfg(1, 2, 1, 0, 0, 1, 1));
    @(negedge clk);
    runBurst(16'h80, 0, 16'h0, 4, 4, 2, 1, 0, "R13", cap, lastCyc);
    waitUntil(lastCyc);
    runBurst(16'h92, 0, 16'h0, 4, 4, 2, 1, 0, "R13", cap2, lastCyc2);
    check(cap2 == lastCyc + 1, "R13", "restart edge", cap2, lastCyc + 1);
    waitUntil(lastCyc2 + 2);

    // R12: output enable low removes the WAIT drive
    outEn = 1'b0;
    #1;
    check(waitOe == 1'b0, "R12", "waitOe with outEn low", int'(waitOe), 0);

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R4", "words left unseen", expQ.size(), 0);
    finishUp();
  end

endmodule